// File: doc/BRIEF.md
# Looping Sample Pattern Memory

This block stores a waveform (a sine tone, a PAM symbol stream, an OFDM frame, or any other sample sequence) for one interleaved converter slice and replays it without end. While the mode input selects write, a slow serial loader fills the store one byte at a time. While it selects read, the whole buffer streams out, one row per fast clock, as several parallel sample lanes that feed the interleaved converter datapath.

The serial clock, data, frame and mode inputs are quasi-static or slow compared with the fast clock. Each passes through a two-stage synchronizer and is sampled in the fast domain, so the block has a single clock. A three-state controller sequences playback. `ST_LOAD` is the write mode. `ST_PRIME` lasts one cycle and fetches row 0. `ST_PLAY` streams rows. The transitions are: LOAD to PRIME when read mode is seen, PRIME to PLAY when read mode persists, and any state to LOAD when write mode is seen. The stream is meant to be started only after all bytes have been loaded.

Top module: `pattern_loop_mem`

## Requirements
- R1: After reset, `lane_valid` is 0 and `lane_data` is all zeros.
- R2: In write mode with `ser_frame` high, each rising edge of `ser_clk` shifts in one bit of `ser_dat`, most significant bit first. Every eight bits form one stored byte.
- R3: The first byte after `ser_frame` rises goes to byte address 0, and each later byte goes to the next address. Dropping `ser_frame` discards any partial byte and returns the address to 0.
- R4: Lane j of `lane_data` (bits 8j+7 down to 8j) carries byte address 4r+j of row r.
- R5: At most five clock cycles after `mode_rd` goes high, `lane_valid` rises, and the first valid row is row 0.
- R6: While `lane_valid` is high, a new row appears on every clock. Row 127 is followed directly by row 0, with no gap cycle.
- R7: When `mode_rd` returns low, `lane_valid` falls and `lane_data` reads all zeros. A later return to read mode starts again from row 0.
- R8: Any mode change discards a partially shifted byte, and the write address restarts at 0.
- R9: Serial clock, data and frame activity during read mode leaves the stored contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast read clock, synchronous to the converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_rd | input | 1 | 1 = read (playback), 0 = write (serial load) |
| ser_clk | input | 1 | Slow serial shift clock, oversampled by clk |
| ser_dat | input | 1 | Serial data bit, MSB first |
| ser_frame | input | 1 | High while a load frame is open |
| lane_valid | output | 1 | High while rows are being streamed |
| lane_data | output | 32 | Four 8-bit sample lanes; lane 0 in the low byte |

## Verification
The hardest case to reach from the ports is a byte abandoned part-way through. Bits must already sit in the shift register when the mode flips, or when the frame drops, and the proof that they were discarded appears only later, in the playback stream. The stimulus shifts three or four bits, then toggles the mode (or closes and reopens the frame), then loads fresh bytes. The read-back of rows 0 and 1 must show only the fresh values, placed at addresses 0 and 1. A second hard case is the wrap seam between row 127 and row 0. It is reached by letting playback run for more than two full buffer periods while a behavioural model follows the expected row on every clock.

// File: rtl/pm_pkg.sv
package pm_pkg;
    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_PRIME = 2'd1,
        ST_PLAY  = 2'd2
    } pm_state_t;
endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pm_serial_loader.sv
module pm_serial_loader #(
    parameter int W      = 8,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              sclk,
    input  logic              sdat,
    input  logic              sframe,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [W-1:0]      wr_byte
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

    logic              sclk_q;
    logic [W-2:0]      shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic [ADDR_W-1:0] addr_ptr;
    logic              rise;
    logic              active;

    assign rise   = sclk & ~sclk_q;
    assign active = load_en & sframe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            shreg    <= '0;
            bitcnt   <= '0;
            addr_ptr <= '0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_byte  <= '0;
        end else begin
            sclk_q <= sclk;
            wr_en  <= 1'b0;
            if (!active) begin
                bitcnt   <= '0;
                addr_ptr <= '0;
            end else if (rise) begin
                shreg <= {shreg[W-3:0], sdat};
                if (bitcnt == LAST_BIT) begin
                    bitcnt   <= '0;
                    wr_en    <= 1'b1;
                    wr_byte  <= {shreg, sdat};
                    wr_addr  <= addr_ptr;
                    addr_ptr <= addr_ptr + 1'b1;
                end else begin
                    bitcnt <= bitcnt + 1'b1;
                end
            end
        end
    end

    // R2
    single_write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R3
    frame_addr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sframe |=> (addr_ptr == '0));

    // R9
    no_write_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> !wr_en);
endmodule

// File: rtl/pm_bank.sv
module pm_bank #(
    parameter int W      = 8,
    parameter int ROWS   = 128,
    parameter int ROW_W  = 7
) (
    input  logic             clk,
    input  logic             we,
    input  logic [ROW_W-1:0] waddr,
    input  logic [W-1:0]     wdata,
    input  logic [ROW_W-1:0] raddr,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/pm_playback_ctrl.sv
module pm_playback_ctrl
    import pm_pkg::*;
#(
    parameter int ROWS  = 128,
    parameter int ROW_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_rd,
    output logic [ROW_W-1:0] rd_row,
    output logic             valid
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    pm_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LOAD;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOAD:  state_nx = mode_rd ? ST_PRIME : ST_LOAD;
            ST_PRIME: state_nx = mode_rd ? ST_PLAY  : ST_LOAD;
            ST_PLAY:  state_nx = mode_rd ? ST_PLAY  : ST_LOAD;
            default:  state_nx = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_row <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= (state_nx == ST_PLAY);
            if (state_nx == ST_PLAY) begin
                rd_row <= (rd_row == LAST_ROW) ? '0 : rd_row + 1'b1;
            end else begin
                rd_row <= '0;
            end
        end
    end

    // R7
    stop_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_rd |=> !valid);

    // R5
    start_after_prime_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> ($past(mode_rd, 1) && $past(mode_rd, 2)));

    // R6
    row_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && mode_rd) |=> (rd_row != $past(rd_row)));
endmodule

// File: rtl/pattern_loop_mem.sv
module pattern_loop_mem #(
    parameter int SAMPLE_W = 8,
    parameter int DEPTH    = 512,
    parameter int LANES    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mode_rd,
    input  logic                      ser_clk,
    input  logic                      ser_dat,
    input  logic                      ser_frame,
    output logic                      lane_valid,
    output logic [LANES*SAMPLE_W-1:0] lane_data
);
    localparam int ROWS   = DEPTH / LANES;
    localparam int ROW_W  = $clog2(ROWS);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int SEL_W  = $clog2(LANES);

    logic [3:0] raw_in, sync_in;
    logic       s_mode, s_sclk, s_sdat, s_frame;

    assign raw_in = {mode_rd, ser_clk, ser_dat, ser_frame};
    assign {s_mode, s_sclk, s_sdat, s_frame} = sync_in;

    pm_sync #(.W(4)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_in)
    );

    logic                wr_en;
    logic [ADDR_W-1:0]   wr_addr;
    logic [SAMPLE_W-1:0] wr_byte;

    pm_serial_loader #(.W(SAMPLE_W), .ADDR_W(ADDR_W)) u_loader (
        .clk(clk), .rst_n(rst_n), .load_en(~s_mode),
        .sclk(s_sclk), .sdat(s_sdat), .sframe(s_frame),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_byte(wr_byte)
    );

    logic [ROW_W-1:0] rd_row;
    logic             play_valid;

    pm_playback_ctrl #(.ROWS(ROWS), .ROW_W(ROW_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_rd(s_mode),
        .rd_row(rd_row), .valid(play_valid)
    );

    logic [LANES*SAMPLE_W-1:0] row_word;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pm_bank #(.W(SAMPLE_W), .ROWS(ROWS), .ROW_W(ROW_W)) u_bank (
            .clk(clk),
            .we(wr_en && (wr_addr[SEL_W-1:0] == SEL_W'(g))),
            .waddr(wr_addr[ADDR_W-1:SEL_W]),
            .wdata(wr_byte),
            .raddr(rd_row),
            .rdata(row_word[g*SAMPLE_W +: SAMPLE_W])
        );
    end

    assign lane_valid = play_valid;
    assign lane_data  = play_valid ? row_word : '0;

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_valid |-> (lane_data == '0));
endmodule

// File: tb/test_pattern_loop_mem.sv
`timescale 1ns/1ps
module test_pattern_loop_mem;
    localparam int DEPTH = 512;
    localparam int LANES = 4;
    localparam int ROWS  = DEPTH / LANES;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_rd = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic ser_frame = 1'b0;
    logic lane_valid;
    logic [31:0] lane_data;

    always #4 clk = ~clk;

    pattern_loop_mem i_pattern_loop_mem (
        .clk(clk), .rst_n(rst_n), .mode_rd(mode_rd),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_frame(ser_frame),
        .lane_valid(lane_valid), .lane_data(lane_data)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit run_mon = 0;
    string phase = "R2";
    logic [7:0] model [DEPTH];
    int exp_row = 0;
    bit prev_valid = 0;
    int wraps = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model, compared on every clock
    always @(negedge clk) begin
        if (rst_n && run_mon) begin
            if (lane_valid) begin
                logic [31:0] exp_word;
                string tag;
                for (int j = 0; j < LANES; j++) exp_word[j*8 +: 8] = model[exp_row*LANES + j];
                if (!prev_valid) tag = "R5";
                else if (exp_row == 0) begin tag = "R6"; wraps++; end
                else tag = "R4";
                check(lane_data == exp_word, {phase, "/", tag}, lane_data, exp_word);
                exp_row = (exp_row + 1) % ROWS;
            end else begin
                check(lane_data == 32'h0, "R7", lane_data, 32'h0);
                exp_row = 0;
            end
            prev_valid = lane_valid;
        end
    end

    task automatic send_bit(input logic b);
        @(negedge clk); ser_dat = b; ser_clk = 1'b0;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        repeat (3) @(negedge clk);
        ser_clk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic enter_read(input string req);
        int n;
        @(negedge clk); mode_rd = 1'b1;
        n = 0;
        while (!lane_valid && n < 8) begin @(negedge clk); n++; end
        check(lane_valid && n <= 5, req, 32'(n), 32'd5);
    endtask

    task automatic enter_write();
        @(negedge clk); mode_rd = 1'b0;
        repeat (4) @(negedge clk);
        check(!lane_valid, "R7", {31'b0, lane_valid}, 32'h0);
    endtask

    initial begin
        #1_200_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check(!lane_valid, "R1", {31'b0, lane_valid}, 32'h0);
        check(lane_data == 32'h0, "R1", lane_data, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_mon = 1;

        // R2 / R3: load a ramp whose two halves differ
        for (int i = 0; i < DEPTH; i++) model[i] = 8'(i) + ((i >= 256) ? 8'h80 : 8'h00);
        @(negedge clk); ser_frame = 1'b1;
        for (int i = 0; i < DEPTH; i++) send_byte(model[i]);
        repeat (6) @(negedge clk); ser_frame = 1'b0;
        repeat (4) @(negedge clk);

        // R5, R6, R9: play more than two periods while serial lines toggle
        phase = "R2";
        enter_read("R5");
        wraps = 0;
        repeat (40) @(negedge clk);
        phase = "R9";
        ser_frame = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk); ser_dat = k[0]; ser_clk = k[1];
        end
        ser_clk = 1'b0; ser_frame = 1'b0;
        repeat (230) @(negedge clk);
        check(wraps >= 2, "R6", 32'(wraps), 32'd2);
        enter_write();

        // R3: frame drop mid-byte discards bits and resets address
        @(negedge clk); ser_frame = 1'b1;
        send_byte(8'h11); send_byte(8'h22);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        repeat (6) @(negedge clk); ser_frame = 1'b0;
        repeat (6) @(negedge clk); ser_frame = 1'b1;
        send_byte(8'h5A);
        repeat (6) @(negedge clk); ser_frame = 1'b0;
        model[0] = 8'h5A; model[1] = 8'h22;
        repeat (4) @(negedge clk);
        phase = "R3";
        enter_read("R7");
        repeat (140) @(negedge clk);
        enter_write();

        // R8: mode flip mid-byte discards bits and resets address
        @(negedge clk); ser_frame = 1'b1;
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        repeat (6) @(negedge clk);
        mode_rd = 1'b1;
        repeat (8) @(negedge clk);
        mode_rd = 1'b0;
        repeat (8) @(negedge clk);
        send_byte(8'hA5); send_byte(8'hC3);
        repeat (6) @(negedge clk); ser_frame = 1'b0;
        model[0] = 8'hA5; model[1] = 8'hC3;
        repeat (4) @(negedge clk);
        phase = "R8";
        enter_read("R5");
        repeat (140) @(negedge clk);
        enter_write();

        run_mon = 0;
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule